// File: doc/BRIEF.md
# NRZI line decoder with bit unstuffing

This block sits behind a line sampler that strobes one mid-bit sample of the differential pair per bit time. It classifies each sample as J, K, single-ended zero (SE0) or single-ended one (SE1), and turns the J/K stream into data bits. A bit is 1 when the line state stays the same and 0 when it changes. A zero inserted by the transmitter after a run of ones is removed, and the SE0-then-J end of packet is recognised.

The sampler raises `sop_i` when it has seen the idle-to-K start transition. From then on the decoder is busy, and its reference state is K. When `eop_o` pulses, the sampler must restore its nominal bit timing and go back to hunting for the next start. `busy_o` stays high from the start of a packet to its end, including any wait after an abort. Polarity of J and K depends on `low_speed_i`.

Top module: `nrzi_unstuff_dec`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after it is released, every output is 0. An assertion of reset in the middle of a packet returns the block to idle.
- R2: `sop_i` in idle makes `busy_o` 1 from the next cycle and loads K as the reference line state. A first data symbol of K therefore decodes as 1, and a first data symbol of J as 0.
- R3: A J/K sample with `sym_valid_i` high produces `bit_valid_o`=1 in the next cycle. `bit_o` is 1 if the sample equals the previous J/K sample, and 0 if it differs.
- R4: The line pair maps to a symbol as follows: {dp,dm}=00 is SE0 and 11 is SE1. With `low_speed_i`=0, 10 is J and 01 is K. With `low_speed_i`=1 these two are swapped.
- R5: A 0 that follows RUN_LEN (default 6) consecutive 1s is dropped. It gives `stuff_drop_o`=1 with `bit_valid_o`=0, and the ones count restarts from zero.
- R6: A data 0 before the run is complete clears the ones count, so only an unbroken run of RUN_LEN ones makes the next 0 a stuffed bit.
- R7: A 1 following RUN_LEN consecutive 1s pulses `stuff_err_o` and aborts the packet. No further bits are emitted until SE0 followed by J is seen.
- R8: An SE0 during the packet ends bit decoding without emitting a bit, and repeated SE0 emits nothing. A J after SE0 pulses `eop_o`, and `busy_o` is 0 in that same cycle.
- R9: An SE1 seen while busy pulses `se1_err_o` and emits no bit. The block then waits for SE0 followed by J.
- R10: Samples with `sym_valid_i` low, and any sample while idle, produce no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| low_speed_i | input | 1 | 1 selects low-speed J/K polarity |
| sop_i | input | 1 | Start-of-packet strobe from the sampler |
| sym_valid_i | input | 1 | Mid-bit sample strobe |
| dp_i | input | 1 | Sampled D+ level |
| dm_i | input | 1 | Sampled D- level |
| bit_o | output | 1 | Decoded data bit |
| bit_valid_o | output | 1 | Data bit strobe |
| stuff_drop_o | output | 1 | Stuffed zero removed |
| eop_o | output | 1 | End of packet; sampler restores timing and idles |
| stuff_err_o | output | 1 | Run of ones too long; packet aborted |
| se1_err_o | output | 1 | SE1 seen during a packet |
| busy_o | output | 1 | Packet in progress |

## Verification
The bench builds the block with the default run length of six. This puts both a legal stuffed zero and a seventh-one abort within a few dozen samples. It also lets a five-ones-then-zero run be shown to restart counting. Both J/K polarities are driven, and so are error recovery through SE0 and J, and reset in the middle of a packet.

// File: rtl/nrzi_pkg.sv
package nrzi_pkg;
  typedef enum logic [1:0] {SYM_SE0, SYM_J, SYM_K, SYM_SE1} sym_e;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_EOP, ST_HOLD} st_e;
endpackage

// File: rtl/nrzi_line_map.sv
module nrzi_line_map
  import nrzi_pkg::*;
(
  input  logic dp_i,
  input  logic dm_i,
  input  logic low_speed_i,
  output sym_e sym_o
);
  always_comb begin
    unique case ({dp_i, dm_i})
      2'b00:   sym_o = SYM_SE0;
      2'b11:   sym_o = SYM_SE1;
      2'b10:   sym_o = low_speed_i ? SYM_K : SYM_J;
      default: sym_o = low_speed_i ? SYM_J : SYM_K;
    endcase
  end
endmodule

// File: rtl/nrzi_run_cnt.sv
module nrzi_run_cnt #(
  parameter int RUN_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic full_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == FULL);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R6
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/nrzi_unstuff_dec.sv
module nrzi_unstuff_dec
  import nrzi_pkg::*;
#(
  parameter int RUN_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_speed_i,
  input  logic sop_i,
  input  logic sym_valid_i,
  input  logic dp_i,
  input  logic dm_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic stuff_drop_o,
  output logic eop_o,
  output logic stuff_err_o,
  output logic se1_err_o,
  output logic busy_o
);
  sym_e sym;
  st_e  st_q, st_n;
  sym_e prev_q, prev_n;
  logic run_full, run_clr, run_inc;
  logic emit, same, stuff, serr, s1err, eop;

  nrzi_line_map u_map (
    .dp_i        (dp_i),
    .dm_i        (dm_i),
    .low_speed_i (low_speed_i),
    .sym_o       (sym)
  );

  nrzi_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (run_clr),
    .inc_i  (run_inc),
    .full_o (run_full)
  );

  assign same = (sym == prev_q);

  always_comb begin
    st_n    = st_q;
    prev_n  = prev_q;
    emit    = 1'b0;
    stuff   = 1'b0;
    serr    = 1'b0;
    s1err   = 1'b0;
    eop     = 1'b0;
    run_clr = 1'b0;
    run_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: if (sop_i) begin
        st_n    = ST_DATA;
        prev_n  = SYM_K;
        run_clr = 1'b1;
      end
      ST_DATA: if (sym_valid_i) begin
        unique case (sym)
          SYM_SE0: st_n = ST_EOP;
          SYM_SE1: begin
            s1err = 1'b1;
            st_n  = ST_HOLD;
          end
          default: begin
            prev_n = sym;
            if (run_full) begin
              run_clr = 1'b1;
              if (same) begin
                serr = 1'b1;
                st_n = ST_HOLD;
              end else begin
                stuff = 1'b1;
              end
            end else begin
              emit    = 1'b1;
              run_inc = same;
              run_clr = !same;
            end
          end
        endcase
      end
      ST_EOP: if (sym_valid_i) begin
        unique case (sym)
          SYM_J: begin
            eop     = 1'b1;
            st_n    = ST_IDLE;
            prev_n  = SYM_J;
            run_clr = 1'b1;
          end
          SYM_SE0: st_n = ST_EOP;
          SYM_SE1: begin
            s1err = 1'b1;
            st_n  = ST_HOLD;
          end
          default: st_n = ST_HOLD;
        endcase
      end
      default: if (sym_valid_i && sym == SYM_SE0) st_n = ST_EOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      prev_q       <= SYM_J;
      bit_o        <= 1'b0;
      bit_valid_o  <= 1'b0;
      stuff_drop_o <= 1'b0;
      eop_o        <= 1'b0;
      stuff_err_o  <= 1'b0;
      se1_err_o    <= 1'b0;
    end else begin
      st_q         <= st_n;
      prev_q       <= prev_n;
      bit_o        <= emit & same;
      bit_valid_o  <= emit;
      stuff_drop_o <= stuff;
      eop_o        <= eop;
      stuff_err_o  <= serr;
      se1_err_o    <= s1err;
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  // R3
  bit_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(sym_valid_i));
  // R2
  busy_from_sop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(sop_i));
  // R8
  eop_idles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> !busy_o);
  // R9
  se1_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    se1_err_o |-> $past(dp_i && dm_i));
  // R7
  err_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |-> $past(run_full));
  // R5
  pulses_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bit_valid_o, stuff_drop_o, eop_o, stuff_err_o, se1_err_o}));
endmodule

// File: tb/nrzi_unstuff_dec_tb.sv
module nrzi_unstuff_dec_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic low_speed = 1'b0, sop = 1'b0, sv = 1'b0, dp = 1'b1, dm = 1'b0;
  logic bit_o, bit_valid, stuff_drop, eop, stuff_err, se1_err, busy;
  int   errors = 0, checks = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  nrzi_unstuff_dec u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .low_speed_i(low_speed), .sop_i(sop),
    .sym_valid_i(sv), .dp_i(dp), .dm_i(dm), .bit_o(bit_o),
    .bit_valid_o(bit_valid), .stuff_drop_o(stuff_drop), .eop_o(eop),
    .stuff_err_o(stuff_err), .se1_err_o(se1_err), .busy_o(busy)
  );

  // entry: [14:11] requirement, [10:7] {sop,valid,dp,dm},
  // [6:0] expected {busy,bit_valid,bit,stuff,eop,stuff_err,se1_err}
  // full speed: J = {dp,dm}=10, K = 01
  localparam int N = 43;
  localparam logic [14:0] TBL [N] = '{
    {4'd10, 4'b0101, 7'b0000000},                     // R10 idle K ignored
    {4'd2,  4'b1000, 7'b1000000},                     // R2 start
    {4'd2,  4'b0101, 7'b1110000},                     // R2 K vs ref K -> 1
    {4'd3,  4'b0110, 7'b1100000},                     // R3 change -> 0
    {4'd10, 4'b0010, 7'b1000000},                     // R10 no strobe
    {4'd3,  4'b0110, 7'b1110000},
    {4'd3,  4'b0101, 7'b1100000},
    {4'd5,  4'b0101, 7'b1110000}, {4'd5, 4'b0101, 7'b1110000}, // R5 six ones
    {4'd5,  4'b0101, 7'b1110000}, {4'd5, 4'b0101, 7'b1110000},
    {4'd5,  4'b0101, 7'b1110000}, {4'd5, 4'b0101, 7'b1110000},
    {4'd5,  4'b0110, 7'b1001000},                     // R5 stuffed zero dropped
    {4'd5,  4'b0110, 7'b1110000},                     // R5 count restarted
    {4'd6,  4'b0110, 7'b1110000}, {4'd6, 4'b0110, 7'b1110000}, // R6
    {4'd6,  4'b0110, 7'b1110000}, {4'd6, 4'b0110, 7'b1110000},
    {4'd6,  4'b0101, 7'b1100000},                     // R6 zero after five ones
    {4'd6,  4'b0101, 7'b1110000}, {4'd6, 4'b0101, 7'b1110000},
    {4'd6,  4'b0101, 7'b1110000}, {4'd6, 4'b0101, 7'b1110000},
    {4'd6,  4'b0101, 7'b1110000}, {4'd6, 4'b0101, 7'b1110000},
    {4'd7,  4'b0101, 7'b1000010},                     // R7 seventh one
    {4'd7,  4'b0101, 7'b1000000},                     // R7 aborted
    {4'd7,  4'b0110, 7'b1000000},
    {4'd8,  4'b0100, 7'b1000000},                     // R8 SE0
    {4'd8,  4'b0110, 7'b0000100},                     // R8 J ends packet
    {4'd2,  4'b1000, 7'b1000000},
    {4'd3,  4'b0110, 7'b1100000},                     // J vs ref K -> 0
    {4'd9,  4'b0111, 7'b1000001},                     // R9 SE1
    {4'd9,  4'b0110, 7'b1000000},
    {4'd9,  4'b0100, 7'b1000000},
    {4'd8,  4'b0100, 7'b1000000},                     // R8 second SE0
    {4'd8,  4'b0110, 7'b0000100},
    {4'd2,  4'b1000, 7'b1000000},
    {4'd2,  4'b0101, 7'b1110000},
    {4'd8,  4'b0100, 7'b1000000},                     // R8 SE0 gives no bit
    {4'd8,  4'b0110, 7'b0000100},
    {4'd10, 4'b0101, 7'b0000000}                      // R10 idle again
  };

  task automatic step(input logic s, input logic v, input logic p, input logic m);
    @(negedge clk);
    sop = s; sv = v; dp = p; dm = m;
    @(posedge clk);
    #1 sop = 1'b0; sv = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [6:0] outs();
    return {busy, bit_valid, bit_o, stuff_drop, eop, stuff_err, se1_err};
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", req, outs(), exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 7'b0000000);          // R1 held in reset
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", 7'b0000000);          // R1 after release
    for (int i = 0; i < N; i++) begin
      step(TBL[i][10], TBL[i][9], TBL[i][8], TBL[i][7]);
      check($sformatf("R%0d entry %0d", TBL[i][14:11], i), TBL[i][6:0]);
    end
    // R4 low-speed polarity: 10 is K, 01 is J
    low_speed = 1'b1;
    step(1, 0, 0, 0);
    step(0, 1, 1, 0); check("R4 ls K", 7'b1110000);
    step(0, 1, 0, 1); check("R4 ls J", 7'b1100000);
    step(0, 1, 0, 0); check("R4 ls SE0", 7'b1000000);
    step(0, 1, 0, 1); check("R4 ls J eop", 7'b0000100);
    low_speed = 1'b0;
    // R1 reset in the middle of a packet
    step(1, 0, 0, 0); check("R1 busy", 7'b1000000);
    rst_ni = 1'b0;
    @(negedge clk); check("R1 mid reset", 7'b0000000);
    rst_ni = 1'b1;
    step(0, 1, 0, 1); check("R1 idle after reset", 7'b0000000);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule